// File: doc/BRIEF.md
# Hart Step and Wait-State Controller

This block sequences one instruction step for a single RISC-V hart each time it receives a one-cycle step strobe. It keeps a two-state hart status, running or waiting. In the running state it decides, with a fixed priority, what the step does: take a pending interrupt, report a fetch fault, raise an illegal-instruction trap for a compressed fetch while compressed support is off, or act on the execute outcome code of a 16-bit or 32-bit instruction. Decode and the execute datapath sit outside the block. The block only sees the outcome code they produce.

A wait-for-interrupt outcome parks the hart in the waiting state. A configuration bit can instead make such an outcome an ordinary retirement. While parked, the block keeps the instruction that caused the wait, zero-extended to 32 bits, along with its length. Later steps can leave the wait in two ways. A wake interrupt retires the parked instruction. A forced exit request either retires it or turns it into an illegal-instruction trap, depending on the privilege level and the timeout-wait control bit. In the trap case the parked bits supply the trap value.

The results are registered and appear one cycle after the strobe. They are a done pulse, a stepped flag, a trap cause, a trap value, a next-PC selection and a 64-bit retired-instruction counter. Software can load the counter. A load made in the same cycle as a step suppresses that step's increment.

Top module: `hart_step_ctrl`

## Requirements
- R1: After reset the hart is running (`waiting_o`=0), `done_o`=0 and `minstret_o`=0.
- R2: Each cycle with `step_i`=1 gives `done_o`=1 in the next cycle, and only then. In that cycle `stepped_o`=1 exactly when the hart ends the step running (`waiting_o`=0).
- R3: While the hart is running, `irq_pending_i`=1 takes priority over the fetch and execute inputs. The step reports cause 1 (interrupt) and pc select 3 (trap), and it does not count.
- R4: PC select encoding: 0 = hold, 1 = advance 2, 2 = advance 4, 3 = trap vector. A retiring compressed fetch (`fetch_kind_i`=1) selects 1. A retiring base fetch (`fetch_kind_i`=0) selects 2.
- R5: A compressed fetch while `comp_en_i`=0 ignores `exec_code_i`. It reports cause 3 (illegal) and pc select 3. The trap value is `fetch_bits_i[15:0]` zero-extended to 32 bits.
- R6: A fetch fault (`fetch_kind_i` = 2 or 3) reports cause 2 and pc select 3, and the step does not count.
- R7: Execute code 1 (wait-for-interrupt) moves the hart to waiting, with `stepped_o`=0 and pc select 0. When `wfi_nop_i`=1 the same code is an ordinary retirement instead. The other execute codes are 0 = retire, 2 = illegal (cause 3, pc select 3) and 3 = other exception (cause 4, pc select 3).
- R8: A step while waiting with `wake_i`=1 returns the hart to running and retires the parked instruction. The pc select advances by the parked length. A pending interrupt is then taken on the following step.
- R9: A step while waiting with `wake_i`=0 and `exit_wait_i`=1 returns the hart to running. It retires the parked instruction when `priv_machine_i`=1 or `tw_i`=0. Otherwise it reports cause 3, pc select 3, and the parked 32-bit bits as the trap value.
- R10: A step while waiting with neither `wake_i` nor `exit_wait_i` keeps the hart waiting, with `stepped_o`=0 and pc select 0. Fetch and execute inputs have no effect, and the counter does not change.
- R11: `minstret_o` rises by exactly one on a step that ends running with a retirement, provided `cnt_inhibit_i`=0 and `cnt_wr_i`=0 in the strobe cycle. Otherwise the step leaves it unchanged.
- R12: With `tval_en_i`=0 the trap value of every step is zero. Cause 0 means no trap.
- R13: `cnt_wr_i`=1 loads `cnt_wdata_i` into `minstret_o` on the next edge, and the load wins over any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One-cycle step strobe |
| exit_wait_i | input | 1 | Forced exit from the waiting state |
| irq_pending_i | input | 1 | Interrupt ready to be taken while running |
| wake_i | input | 1 | Wake interrupt while waiting |
| fetch_kind_i | input | 2 | 0 base, 1 compressed, 2/3 fetch fault |
| fetch_bits_i | input | 32 | Fetched instruction bits |
| exec_code_i | input | 2 | 0 retire, 1 wait-for-interrupt, 2 illegal, 3 other exception |
| priv_machine_i | input | 1 | Current privilege is Machine |
| tw_i | input | 1 | Timeout-wait control bit |
| comp_en_i | input | 1 | Compressed instructions enabled |
| wfi_nop_i | input | 1 | Treat wait-for-interrupt as a retirement |
| tval_en_i | input | 1 | Report instruction bits as trap value |
| cnt_inhibit_i | input | 1 | Retired-instruction counting inhibited |
| cnt_wr_i | input | 1 | Software write of the counter |
| cnt_wdata_i | input | 64 | Counter write data |
| done_o | output | 1 | Step result valid |
| stepped_o | output | 1 | Step ended with the hart running |
| waiting_o | output | 1 | Hart is in the waiting state |
| trap_cause_o | output | 3 | 0 none, 1 interrupt, 2 fetch fault, 3 illegal, 4 other exception |
| trap_val_o | output | 32 | Trap value |
| pc_sel_o | output | 2 | Next-PC selection |
| minstret_o | output | 64 | Retired-instruction counter |

## Verification
The assertions assume that `step_i` is a single-cycle pulse. They also assume that the fetch, execute, wake, exit and configuration inputs are valid and steady in the strobe cycle, and that every input is low while reset is held. The stimulus meets these conditions. It drives all inputs on the falling edge, raises the strobe for exactly one cycle and clears it before the next step. It also keeps every input at zero through reset. Counter loads are driven both alone and together with a step, so that the load-over-increment rule is exercised.

// File: rtl/hstep_pkg.sv
package hstep_pkg;
    localparam int INST_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_INTR  = 3'd1,
        CAUSE_FETCH = 3'd2,
        CAUSE_ILL   = 3'd3,
        CAUSE_EXC   = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_ADV2 = 2'd1,
        PC_ADV4 = 2'd2,
        PC_TRAP = 2'd3
    } pcsel_e;

    localparam logic [1:0] FK_BASE = 2'd0;
    localparam logic [1:0] FK_COMP = 2'd1;

    localparam logic [1:0] EX_RETIRE = 2'd0;
    localparam logic [1:0] EX_WFI    = 2'd1;
    localparam logic [1:0] EX_ILL    = 2'd2;

    typedef struct packed {
        logic              retire;
        logic              wait_next;
        cause_e            cause;
        logic [INST_W-1:0] tval;
        pcsel_e            pcsel;
        logic [INST_W-1:0] park_bits;
        logic              park_comp;
    } outcome_t;
endpackage

// File: rtl/hstep_active.sv
module hstep_active
    import hstep_pkg::*;
(
    input  logic              irq_pending_i,
    input  logic [1:0]        fetch_kind_i,
    input  logic [INST_W-1:0] fetch_bits_i,
    input  logic [1:0]        exec_code_i,
    input  logic              comp_en_i,
    input  logic              wfi_nop_i,
    input  logic              tval_en_i,
    output outcome_t          oc_o
);
    logic              is_comp;
    logic [INST_W-1:0] inst_bits;
    pcsel_e            adv_sel;

    always_comb begin
        is_comp   = (fetch_kind_i == FK_COMP);
        inst_bits = is_comp ? {{(INST_W-HALF_W){1'b0}}, fetch_bits_i[HALF_W-1:0]}
                            : fetch_bits_i;
        adv_sel   = is_comp ? PC_ADV2 : PC_ADV4;

        oc_o           = '0;
        oc_o.cause     = CAUSE_NONE;
        oc_o.pcsel     = PC_HOLD;
        oc_o.park_bits = inst_bits;
        oc_o.park_comp = is_comp;

        if (irq_pending_i) begin
            oc_o.cause = CAUSE_INTR;
            oc_o.pcsel = PC_TRAP;
        end else if (fetch_kind_i != FK_BASE && !is_comp) begin
            oc_o.cause = CAUSE_FETCH;
            oc_o.pcsel = PC_TRAP;
        end else if (is_comp && !comp_en_i) begin
            oc_o.cause = CAUSE_ILL;
            oc_o.tval  = tval_en_i ? inst_bits : '0;
            oc_o.pcsel = PC_TRAP;
        end else begin
            case (exec_code_i)
                EX_RETIRE: begin
                    oc_o.retire = 1'b1;
                    oc_o.pcsel  = adv_sel;
                end
                EX_WFI: begin
                    if (wfi_nop_i) begin
                        oc_o.retire = 1'b1;
                        oc_o.pcsel  = adv_sel;
                    end else begin
                        oc_o.wait_next = 1'b1;
                    end
                end
                EX_ILL: begin
                    oc_o.cause = CAUSE_ILL;
                    oc_o.tval  = tval_en_i ? inst_bits : '0;
                    oc_o.pcsel = PC_TRAP;
                end
                default: begin
                    oc_o.cause = CAUSE_EXC;
                    oc_o.pcsel = PC_TRAP;
                end
            endcase
        end
    end
endmodule

// File: rtl/hstep_wait.sv
module hstep_wait
    import hstep_pkg::*;
(
    input  logic              wake_i,
    input  logic              exit_wait_i,
    input  logic              priv_machine_i,
    input  logic              tw_i,
    input  logic              tval_en_i,
    input  logic [INST_W-1:0] park_bits_i,
    input  logic              park_comp_i,
    output outcome_t          oc_o
);
    always_comb begin
        oc_o           = '0;
        oc_o.cause     = CAUSE_NONE;
        oc_o.pcsel     = PC_HOLD;
        oc_o.park_bits = park_bits_i;
        oc_o.park_comp = park_comp_i;

        if (wake_i) begin
            oc_o.retire = 1'b1;
            oc_o.pcsel  = park_comp_i ? PC_ADV2 : PC_ADV4;
        end else if (exit_wait_i) begin
            if (priv_machine_i || !tw_i) begin
                oc_o.retire = 1'b1;
                oc_o.pcsel  = park_comp_i ? PC_ADV2 : PC_ADV4;
            end else begin
                oc_o.cause = CAUSE_ILL;
                oc_o.tval  = tval_en_i ? park_bits_i : '0;
                oc_o.pcsel = PC_TRAP;
            end
        end else begin
            oc_o.wait_next = 1'b1;
        end
    end
endmodule

// File: rtl/hstep_counter.sv
module hstep_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = load_val_i;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R13: a software load is visible on the next edge
    a_r13_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(load_val_i));

    // R11: without a load the counter moves by at most one
    a_r11_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hart_step_ctrl.sv
module hart_step_ctrl
    import hstep_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             exit_wait_i,
    input  logic             irq_pending_i,
    input  logic             wake_i,
    input  logic [1:0]       fetch_kind_i,
    input  logic [31:0]      fetch_bits_i,
    input  logic [1:0]       exec_code_i,
    input  logic             priv_machine_i,
    input  logic             tw_i,
    input  logic             comp_en_i,
    input  logic             wfi_nop_i,
    input  logic             tval_en_i,
    input  logic             cnt_inhibit_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    output logic             done_o,
    output logic             stepped_o,
    output logic             waiting_o,
    output logic [2:0]       trap_cause_o,
    output logic [31:0]      trap_val_o,
    output logic [1:0]       pc_sel_o,
    output logic [CNT_W-1:0] minstret_o
);
    typedef struct packed {
        logic              waiting;
        logic [INST_W-1:0] park_bits;
        logic              park_comp;
        logic              done;
        logic              stepped;
        cause_e            cause;
        logic [INST_W-1:0] tval;
        pcsel_e            pcsel;
    } state_t;

    state_t   st_d, st_q;
    outcome_t act_oc, wait_oc, sel_oc;
    logic     inc_d;

    hstep_active u_active (
        .irq_pending_i (irq_pending_i),
        .fetch_kind_i  (fetch_kind_i),
        .fetch_bits_i  (fetch_bits_i),
        .exec_code_i   (exec_code_i),
        .comp_en_i     (comp_en_i),
        .wfi_nop_i     (wfi_nop_i),
        .tval_en_i     (tval_en_i),
        .oc_o          (act_oc)
    );

    hstep_wait u_wait (
        .wake_i         (wake_i),
        .exit_wait_i    (exit_wait_i),
        .priv_machine_i (priv_machine_i),
        .tw_i           (tw_i),
        .tval_en_i      (tval_en_i),
        .park_bits_i    (st_q.park_bits),
        .park_comp_i    (st_q.park_comp),
        .oc_o           (wait_oc)
    );

    always_comb begin
        sel_oc     = st_q.waiting ? wait_oc : act_oc;
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.cause = CAUSE_NONE;
        st_d.tval  = '0;
        st_d.pcsel = PC_HOLD;
        inc_d      = 1'b0;
        if (step_i) begin
            st_d.done    = 1'b1;
            st_d.waiting = sel_oc.wait_next;
            st_d.stepped = !sel_oc.wait_next;
            st_d.cause   = sel_oc.cause;
            st_d.tval    = sel_oc.tval;
            st_d.pcsel   = sel_oc.pcsel;
            if (!st_q.waiting && sel_oc.wait_next) begin
                st_d.park_bits = sel_oc.park_bits;
                st_d.park_comp = sel_oc.park_comp;
            end
            inc_d = sel_oc.retire && !sel_oc.wait_next && !cnt_inhibit_i && !cnt_wr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cause <= CAUSE_NONE;
            st_q.pcsel <= PC_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    hstep_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_wr_i),
        .load_val_i (cnt_wdata_i),
        .inc_i      (inc_d),
        .cnt_o      (minstret_o)
    );

    assign done_o       = st_q.done;
    assign stepped_o    = st_q.stepped;
    assign waiting_o    = st_q.waiting;
    assign trap_cause_o = st_q.cause;
    assign trap_val_o   = st_q.tval;
    assign pc_sel_o     = st_q.pcsel;

    // R2: result strobe follows every step strobe and nothing else
    a_r2_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> done_o);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> !done_o);

    // R3: an interrupt is taken first and never counts
    a_r3_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !waiting_o && irq_pending_i && !cnt_wr_i)
        |=> (trap_cause_o == 3'd1 && minstret_o == $past(minstret_o)));

    // R10: an idle wait step stays parked
    a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && waiting_o && !wake_i && !exit_wait_i)
        |=> (waiting_o && !stepped_o && pc_sel_o == 2'd0));

    // R11: inhibited counting leaves the counter alone
    a_r11_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cnt_inhibit_i && !cnt_wr_i) |=> minstret_o == $past(minstret_o));

    // R12: trap value stays zero when reporting is off
    a_r12_tval_off: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !tval_en_i) |=> trap_val_o == '0);
endmodule

// File: tb/tb_hart_step_ctrl.sv
module tb_hart_step_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, exit_wait_i = 0, irq_pending_i = 0, wake_i = 0;
    logic [1:0]  fetch_kind_i = 0, exec_code_i = 0;
    logic [31:0] fetch_bits_i = 0;
    logic        priv_machine_i = 0, tw_i = 0, comp_en_i = 0, wfi_nop_i = 0;
    logic        tval_en_i = 0, cnt_inhibit_i = 0, cnt_wr_i = 0;
    logic [63:0] cnt_wdata_i = 0;
    logic        done_o, stepped_o, waiting_o;
    logic [2:0]  trap_cause_o;
    logic [31:0] trap_val_o;
    logic [1:0]  pc_sel_o;
    logic [63:0] minstret_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_step_ctrl dut (.*);

    typedef struct packed {
        logic        stepped;
        logic        waiting;
        logic [2:0]  cause;
        logic [31:0] tval;
        logic [1:0]  pcsel;
        logic [63:0] cnt;
    } exp_t;

    exp_t exp_q[$];
    int   req_q[$];
    int   checks = 0;
    int   fails = 0;

    logic        m_wait = 0;
    logic [31:0] m_bits = 0;
    logic [1:0]  m_len = 0;
    logic [63:0] m_cnt = 0;

    task automatic go(input int req);
        exp_t e;
        logic retire;
        logic [31:0] ib;
        logic [1:0] len;
        retire = 0;
        e = '0;
        if (!m_wait) begin
            ib  = (fetch_kind_i == 2'd1) ? {16'h0, fetch_bits_i[15:0]} : fetch_bits_i;
            len = (fetch_kind_i == 2'd1) ? 2'd1 : 2'd2;
            if (irq_pending_i) begin
                e.cause = 3'd1; e.pcsel = 2'd3;
            end else if (fetch_kind_i >= 2'd2) begin
                e.cause = 3'd2; e.pcsel = 2'd3;
            end else if (fetch_kind_i == 2'd1 && !comp_en_i) begin
                e.cause = 3'd3; e.pcsel = 2'd3; e.tval = tval_en_i ? ib : 32'h0;
            end else if (exec_code_i == 2'd0) begin
                retire = 1; e.pcsel = len;
            end else if (exec_code_i == 2'd1) begin
                if (wfi_nop_i) begin
                    retire = 1; e.pcsel = len;
                end else begin
                    m_wait = 1; m_bits = ib; m_len = len;
                end
            end else if (exec_code_i == 2'd2) begin
                e.cause = 3'd3; e.pcsel = 2'd3; e.tval = tval_en_i ? ib : 32'h0;
            end else begin
                e.cause = 3'd4; e.pcsel = 2'd3;
            end
        end else begin
            if (wake_i) begin
                m_wait = 0; retire = 1; e.pcsel = m_len;
            end else if (exit_wait_i) begin
                m_wait = 0;
                if (priv_machine_i || !tw_i) begin
                    retire = 1; e.pcsel = m_len;
                end else begin
                    e.cause = 3'd3; e.pcsel = 2'd3; e.tval = tval_en_i ? m_bits : 32'h0;
                end
            end
        end
        if (cnt_wr_i) m_cnt = cnt_wdata_i;
        else if (retire && !m_wait && !cnt_inhibit_i) m_cnt = m_cnt + 1;
        e.stepped = !m_wait;
        e.waiting = m_wait;
        e.cnt     = m_cnt;
        exp_q.push_back(e);
        req_q.push_back(req);
        step_i = 1;
        @(negedge clk);
        step_i = 0;
        cnt_wr_i = 0;
        irq_pending_i = 0; wake_i = 0; exit_wait_i = 0;
    endtask

    task automatic sw_write(input logic [63:0] v);
        cnt_wr_i = 1; cnt_wdata_i = v; m_cnt = v;
        @(negedge clk);
        cnt_wr_i = 0;
        checks++;
        if (minstret_o !== v) begin
            fails++;
            $display("FAIL R13 counter load: actual %h expected %h", minstret_o, v);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            exp_t e;
            exp_t a;
            int r;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected done: actual 1 expected 0");
            end else begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
                a = {stepped_o, waiting_o, trap_cause_o, trap_val_o, pc_sel_o, minstret_o};
                if (a !== e) begin
                    fails++;
                    $display("FAIL R%0d step: actual st=%b w=%b c=%0d v=%h pc=%0d n=%0d expected st=%b w=%b c=%0d v=%h pc=%0d n=%0d",
                             r, a.stepped, a.waiting, a.cause, a.tval, a.pcsel, a.cnt,
                             e.stepped, e.waiting, e.cause, e.tval, e.pcsel, e.cnt);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (waiting_o !== 0 || done_o !== 0 || minstret_o !== 64'd0) begin
            fails++;
            $display("FAIL R1 reset: actual w=%b d=%b n=%0d expected 0 0 0", waiting_o, done_o, minstret_o);
        end

        comp_en_i = 1; tval_en_i = 1;
        // R4 R11: base retire advances 4 and counts
        fetch_kind_i = 0; fetch_bits_i = 32'h0000_0013; exec_code_i = 0; go(4);
        // R4: compressed retire advances 2
        fetch_kind_i = 1; fetch_bits_i = 32'hFFFF_4501; go(4);
        // R5: compressed while disabled, upper bits dropped, exec ignored
        comp_en_i = 0; exec_code_i = 0; fetch_bits_i = 32'hABCD_1234; go(5);
        comp_en_i = 1;
        // R6: fetch faults
        fetch_kind_i = 2; go(6);
        fetch_kind_i = 3; go(6);
        // R3: interrupt beats a retiring fetch
        fetch_kind_i = 0; exec_code_i = 0; irq_pending_i = 1; go(3);
        // R7 R12: other exception and illegal execute codes
        exec_code_i = 3; go(7);
        exec_code_i = 2; fetch_bits_i = 32'hDEAD_BEEF; go(7);
        tval_en_i = 0; go(12);
        tval_en_i = 1;
        // R7: wait-for-interrupt as nop
        wfi_nop_i = 1; exec_code_i = 1; fetch_bits_i = 32'h1050_0073; go(7);
        wfi_nop_i = 0;
        // R7: enter wait
        go(7);
        // R10: idle wait steps ignore fetch/exec
        exec_code_i = 0; fetch_kind_i = 1; go(10);
        exec_code_i = 3; irq_pending_i = 0; go(10);
        // R8: wake retires parked base instruction, then interrupt is taken
        wake_i = 1; go(8);
        irq_pending_i = 1; go(8);
        // R9: compressed wait, forced exit user tw=1 traps with parked bits
        fetch_kind_i = 1; fetch_bits_i = 32'h7777_0001; exec_code_i = 1; go(7);
        priv_machine_i = 0; tw_i = 1; exit_wait_i = 1; go(9);
        // R9: machine mode with tw=1 retires
        fetch_kind_i = 0; fetch_bits_i = 32'h1050_0073; go(7);
        priv_machine_i = 1; exit_wait_i = 1; go(9);
        // R9: user mode with tw=0 retires, compressed length
        fetch_kind_i = 1; go(7);
        priv_machine_i = 0; tw_i = 0; exit_wait_i = 1; go(9);
        // R9 R12: trap with tval reporting off
        fetch_kind_i = 0; go(7);
        tw_i = 1; tval_en_i = 0; exit_wait_i = 1; go(12);
        tval_en_i = 1;
        // R11: inhibited retire does not count
        exec_code_i = 0; cnt_inhibit_i = 1; go(11);
        cnt_inhibit_i = 0;
        // R13: load alone, then load wins over a retiring step
        sw_write(64'hFFFF_FFFF_FFFF_FFFE);
        go(11);
        go(11);
        cnt_wr_i = 1; cnt_wdata_i = 64'd500; go(13);
        go(11);

        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing done: actual %0d pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule